// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms 24-bit effective addresses for a processor front end that runs with a 24-bit address space. On a `start` pulse it reads an addressing-mode code together with an absolute field, a displacement field, the address of the following instruction and a small immediate. One cycle later it presents a registered address with a one-cycle `ea_valid` strobe. Branch-class results also carry an `odd_target` flag whenever the address is not even.

Most modes resolve in a single cycle. Short absolute addresses fold into the top page, and mid-width absolutes are sign-extended. Wide absolutes are truncated to 24 bits. Program-counter-relative targets add a sign-extended displacement to the next-instruction address and wrap modulo 2^24. Trap vectors come from a parameterised base plus a scaled index.

The memory-indirect mode is the exception. It forms a table address in the lowest 256 bytes and raises a read request. It then waits for the acknowledge and returns the fetched longword with its top byte dropped. A separate combinational output turns a 3-bit bit-number immediate into a one-hot byte mask.

Top module: `ea_gen`

## Requirements
- R1: After reset, `ea_valid`, `odd_target`, `busy` and `rd_req` are low and `ea_addr` is zero.
- R2: Mode 0 (short absolute) yields `{16'hFFFF, abs_fld[7:0]}`. `ea_valid` is high in the cycle after `start` is sampled, and the upper bits of `abs_fld` have no effect.
- R3: Mode 1 (mid absolute) yields `abs_fld[15:0]` sign-extended to 24 bits, so results are 0x000000..0x007FFF or 0xFF8000..0xFFFFFF.
- R4: Mode 2 (program absolute) and mode 3 (long data absolute) yield `abs_fld[23:0]`, and `abs_fld[31:24]` is ignored.
- R5: Mode 4 adds `disp_fld[7:0]`, sign-extended, to `next_pc`. Mode 5 adds `disp_fld[15:0]`, sign-extended, to `next_pc`. The sum keeps only its low 24 bits.
- R6: `odd_target` is high together with `ea_valid` exactly when the mode is branch-class (2, 4, 5 or 6) and bit 0 of the result is 1. Otherwise it is low.
- R7: Mode 6 (memory indirect) raises `rd_req` and `busy` in the cycle after `start`, with `rd_addr = {16'h0000, abs_fld[7:0]}`. Both are held, with `rd_addr` unchanged, until `rd_ack` is sampled high.
- R8: In the cycle after `rd_ack` is sampled with `rd_req` high, `ea_valid` is high with `ea_addr = rd_data[23:0]`, and `busy` and `rd_req` are low.
- R9: Mode 7 (trap vector) yields `VEC_BASE + 4*(imm_code[1:0] + TRAP_OFS)`. With the defaults (base 0, offset 8) this is 0x20, 0x24, 0x28 or 0x2C.
- R10: `bit_mask` is the one-hot decode of `imm_code[2:0]`, with bit n set for value n.
- R11: A `start` while `busy` is high is ignored. It produces no strobe and leaves the pending read unchanged.
- R12: `ea_valid` is high only in a cycle that follows an accepted single-cycle `start` or an acknowledged read. Back-to-back accepted starts give strobes on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an address computation |
| mode | input | 3 | Addressing-mode code (0..7) |
| abs_fld | input | 32 | Absolute address or table index field |
| disp_fld | input | 16 | PC-relative displacement field |
| next_pc | input | 24 | Address of the following instruction |
| imm_code | input | 3 | Trap index (low 2 bits) or bit number |
| rd_ack | input | 1 | Read acknowledge for the indirect fetch |
| rd_data | input | 32 | Longword returned by the indirect fetch |
| ea_valid | output | 1 | One-cycle result strobe |
| ea_addr | output | 24 | Computed effective address |
| odd_target | output | 1 | Branch-class result with bit 0 set |
| busy | output | 1 | Indirect fetch outstanding |
| rd_req | output | 1 | Read request for the indirect fetch |
| rd_addr | output | 24 | Table address of the indirect fetch |
| bit_mask | output | 8 | One-hot decode of the bit number |

## Verification
The only state in the unit is the output register and the pending-read flag with its table address. A corrupted output register shows up on the very next strobe as a wrong address, a wrong odd flag or a strobe with no cause. A corrupted pending flag shows up within one cycle: `rd_req` drops early, `rd_addr` drifts while the request waits, a start given during the wait is accepted, or no strobe follows the acknowledge.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

   typedef enum logic [2:0] {
      EA_ABS_SHORT = 3'd0,
      EA_ABS_MID   = 3'd1,
      EA_ABS_PROG  = 3'd2,
      EA_ABS_LONG  = 3'd3,
      EA_PC_NEAR   = 3'd4,
      EA_PC_FAR    = 3'd5,
      EA_MEM_IND   = 3'd6,
      EA_TRAP_VEC  = 3'd7
   } ea_mode_e;

   function automatic logic ea_is_branch(input ea_mode_e m);
      return (m == EA_ABS_PROG) || (m == EA_PC_NEAR) ||
             (m == EA_PC_FAR)   || (m == EA_MEM_IND);
   endfunction

endpackage

// File: rtl/ea_abs_fmt.sv
module ea_abs_fmt #(
   parameter int ADDR_W  = 24,
   parameter int ABS_W   = 32,
   parameter int SHORT_W = 8,
   parameter int MID_W   = 16
) (
   input  logic [1:0]        sel,
   input  logic [ABS_W-1:0]  abs_fld,
   output logic [ADDR_W-1:0] addr
);
   localparam int SHORT_PAD = ADDR_W - SHORT_W;
   localparam int MID_PAD   = ADDR_W - MID_W;

   generate
      if (SHORT_W >= MID_W || MID_W >= ADDR_W || ABS_W < ADDR_W) begin : g_bad
         $error("ea_abs_fmt: field widths must satisfy SHORT_W < MID_W < ADDR_W <= ABS_W");
      end
   endgenerate

   logic [ADDR_W-1:0] short_a, mid_a, full_a;

   assign short_a = {{SHORT_PAD{1'b1}}, abs_fld[SHORT_W-1:0]};
   assign mid_a   = {{MID_PAD{abs_fld[MID_W-1]}}, abs_fld[MID_W-1:0]};
   assign full_a  = abs_fld[ADDR_W-1:0];

   always_comb begin
      unique case (sel)
         2'd0:    addr = short_a;
         2'd1:    addr = mid_a;
         default: addr = full_a;
      endcase
   end
endmodule

// File: rtl/ea_pcrel.sv
module ea_pcrel #(
   parameter int ADDR_W = 24,
   parameter int NEAR_W = 8,
   parameter int FAR_W  = 16
) (
   input  logic              far_sel,
   input  logic [FAR_W-1:0]  disp,
   input  logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] target
);
   localparam int NEAR_PAD = ADDR_W - NEAR_W;
   localparam int FAR_PAD  = ADDR_W - FAR_W;

   generate
      if (NEAR_W >= FAR_W || FAR_W >= ADDR_W) begin : g_bad
         $error("ea_pcrel: need NEAR_W < FAR_W < ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] near_x, far_x, ofs;

   assign near_x = {{NEAR_PAD{disp[NEAR_W-1]}}, disp[NEAR_W-1:0]};
   assign far_x  = {{FAR_PAD{disp[FAR_W-1]}}, disp};
   assign ofs    = far_sel ? far_x : near_x;
   // Carry out of the top bit is dropped: the sum wraps modulo 2^ADDR_W.
   assign target = next_pc + ofs;
endmodule

// File: rtl/ea_trap_bit.sv
module ea_trap_bit #(
   parameter int ADDR_W    = 24,
   parameter int IMM_W     = 3,
   parameter int TRAP_W    = 2,
   parameter int VEC_BASE  = 0,
   parameter int TRAP_OFS  = 8,
   parameter int VEC_SHIFT = 2
) (
   input  logic [IMM_W-1:0]       imm,
   output logic [ADDR_W-1:0]      vec,
   output logic [(1<<IMM_W)-1:0]  mask
);
   localparam int                MASK_W = 1 << IMM_W;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] OFS_A  = ADDR_W'(TRAP_OFS);

   generate
      if (TRAP_W > IMM_W || TRAP_OFS < 0 || VEC_BASE < 0) begin : g_bad
         $error("ea_trap_bit: bad trap parameters");
      end
   endgenerate

   logic [ADDR_W-1:0] idx;

   generate
      if (TRAP_OFS == 0) begin : g_no_ofs
         assign idx = ADDR_W'(imm[TRAP_W-1:0]);
      end else begin : g_ofs
         assign idx = ADDR_W'(imm[TRAP_W-1:0]) + OFS_A;
      end
   endgenerate

   assign vec = BASE_A + (idx << VEC_SHIFT);

   generate
      for (genvar b = 0; b < MASK_W; b++) begin : g_mask
         assign mask[b] = (imm == IMM_W'(b));
      end
   endgenerate
endmodule

// File: rtl/ea_ind_seq.sv
module ea_ind_seq #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [IDX_W-1:0]  idx,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              done,
   output logic [ADDR_W-1:0] target
);
   generate
      if (DATA_W < ADDR_W || IDX_W >= ADDR_W) begin : g_bad
         $error("ea_ind_seq: need IDX_W < ADDR_W <= DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req  <= 1'b0;
         rd_addr <= '0;
      end else if (rd_req) begin
         if (rd_ack) rd_req <= 1'b0;
      end else if (launch) begin
         rd_req  <= 1'b1;
         rd_addr <= ADDR_W'(idx);
      end
   end

   assign done   = rd_req & rd_ack;
   // Bits above ADDR_W of the fetched longword are treated as zero.
   assign target = rd_data[ADDR_W-1:0];
endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int ABS_W     = 32,
   parameter int DISP_W    = 16,
   parameter int DATA_W    = 32,
   parameter int SHORT_W   = 8,
   parameter int NEAR_W    = 8,
   parameter int IMM_W     = 3,
   parameter int VEC_BASE  = 0,
   parameter int TRAP_OFS  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [2:0]            mode,
   input  logic [ABS_W-1:0]      abs_fld,
   input  logic [DISP_W-1:0]     disp_fld,
   input  logic [ADDR_W-1:0]     next_pc,
   input  logic [IMM_W-1:0]      imm_code,
   input  logic                  rd_ack,
   input  logic [DATA_W-1:0]     rd_data,
   output logic                  ea_valid,
   output logic [ADDR_W-1:0]     ea_addr,
   output logic                  odd_target,
   output logic                  busy,
   output logic                  rd_req,
   output logic [ADDR_W-1:0]     rd_addr,
   output logic [(1<<IMM_W)-1:0] bit_mask
);
   localparam int MID_W = DISP_W;

   ea_mode_e          m;
   logic              accept, launch, ind_done;
   logic [ADDR_W-1:0] abs_a, rel_a, trap_a, ind_a, direct_a;

   assign m      = ea_mode_e'(mode);
   assign busy   = rd_req;
   assign accept = start & ~busy;
   assign launch = accept & (m == EA_MEM_IND);

   ea_abs_fmt #(
      .ADDR_W(ADDR_W), .ABS_W(ABS_W), .SHORT_W(SHORT_W), .MID_W(MID_W)
   ) i_abs (
      .sel(mode[1:0]), .abs_fld(abs_fld), .addr(abs_a)
   );

   ea_pcrel #(
      .ADDR_W(ADDR_W), .NEAR_W(NEAR_W), .FAR_W(DISP_W)
   ) i_rel (
      .far_sel(mode[0]), .disp(disp_fld), .next_pc(next_pc), .target(rel_a)
   );

   ea_trap_bit #(
      .ADDR_W(ADDR_W), .IMM_W(IMM_W), .TRAP_W(2),
      .VEC_BASE(VEC_BASE), .TRAP_OFS(TRAP_OFS), .VEC_SHIFT(2)
   ) i_trap (
      .imm(imm_code), .vec(trap_a), .mask(bit_mask)
   );

   ea_ind_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(SHORT_W)
   ) i_ind (
      .clk(clk), .rst_n(rst_n), .launch(launch), .idx(abs_fld[SHORT_W-1:0]),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
      .done(ind_done), .target(ind_a)
   );

   always_comb begin
      unique case (m)
         EA_PC_NEAR, EA_PC_FAR: direct_a = rel_a;
         EA_TRAP_VEC:           direct_a = trap_a;
         default:               direct_a = abs_a;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_valid   <= 1'b0;
         ea_addr    <= '0;
         odd_target <= 1'b0;
      end else if (ind_done) begin
         ea_valid   <= 1'b1;
         ea_addr    <= ind_a;
         odd_target <= ind_a[0];
      end else if (accept && m != EA_MEM_IND) begin
         ea_valid   <= 1'b1;
         ea_addr    <= direct_a;
         odd_target <= ea_is_branch(m) & direct_a[0];
      end else begin
         ea_valid   <= 1'b0;
         odd_target <= 1'b0;
      end
   end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        mode,
   input logic              rd_ack,
   input logic [DATA_W-1:0] rd_data,
   input logic              ea_valid,
   input logic [ADDR_W-1:0] ea_addr,
   input logic              odd_target,
   input logic              busy,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        bit_mask
);
   AST_SHORT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 3'd0) |=> (ea_valid && ea_addr[ADDR_W-1:8] == '1)); // R2
   AST_ODD_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      odd_target |-> (ea_valid && ea_addr[0])); // R6
   AST_TABLE_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[ADDR_W-1:8] == '0)); // R7
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R7
   AST_IND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack) |=> (ea_valid && !busy && ea_addr == $past(rd_data[ADDR_W-1:0]))); // R8
   AST_BITMASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bit_mask) == 1); // R10
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !rd_ack) |=> !ea_valid); // R11
   AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |-> ($past(start && !busy && mode != 3'd6) || $past(rd_req && rd_ack))); // R12
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ea_gen_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rd_ack(rd_ack),
   .rd_data(rd_data), .ea_valid(ea_valid), .ea_addr(ea_addr),
   .odd_target(odd_target), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
   .bit_mask(bit_mask)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [31:0] abs_fld = '0;
   logic [15:0] disp_fld = '0;
   logic [23:0] next_pc = '0;
   logic [2:0]  imm_code = '0;
   logic        rd_ack = 1'b0;
   logic [31:0] rd_data = '0;
   logic        ea_valid, odd_target, busy, rd_req;
   logic [23:0] ea_addr, rd_addr;
   logic [7:0]  bit_mask;

   int checks = 0;
   int fails  = 0;
   logic [23:0] q_addr[$];
   logic        q_odd[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   ea_gen i_ea_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .abs_fld(abs_fld),
      .disp_fld(disp_fld), .next_pc(next_pc), .imm_code(imm_code),
      .rd_ack(rd_ack), .rd_data(rd_data), .ea_valid(ea_valid), .ea_addr(ea_addr),
      .odd_target(odd_target), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
      .bit_mask(bit_mask)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] model(input logic [2:0] md, input logic [31:0] a,
                                         input logic [15:0] d, input logic [23:0] pc,
                                         input logic [2:0] im);
      case (md)
         3'd0: return 24'hFFFF00 | {16'h0, a[7:0]};
         3'd1: return a[15] ? {8'hFF, a[15:0]} : {8'h00, a[15:0]};
         3'd2, 3'd3: return a[23:0];
         3'd4: return pc + (d[7] ? {16'hFFFF, d[7:0]} : {16'h0, d[7:0]});
         3'd5: return pc + (d[15] ? {8'hFF, d} : {8'h00, d});
         default: return 24'd4 * (24'(im[1:0]) + 24'd8);
      endcase
   endfunction

   // Driver: one-cycle start, expected result pushed for the monitor.
   task automatic issue(input string tag, input logic [2:0] md, input logic [31:0] a,
                        input logic [15:0] d, input logic [23:0] pc, input logic [2:0] im);
      logic [23:0] e;
      e = model(md, a, d, pc, im);
      start = 1'b1; mode = md; abs_fld = a; disp_fld = d; next_pc = pc; imm_code = im;
      q_addr.push_back(e);
      q_odd.push_back((md == 3'd2 || md == 3'd4 || md == 3'd5) && e[0]);
      q_tag.push_back(tag);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic indirect(input logic [31:0] a, input logic [31:0] data, input int waits);
      start = 1'b1; mode = 3'd6; abs_fld = a;
      @(negedge clk);
      start = 1'b0;
      chk("R7 rd_req", 32'(rd_req), 1);
      chk("R7 busy", 32'(busy), 1);
      chk("R7 rd_addr", 32'(rd_addr), {24'h0, a[7:0]});
      for (int i = 0; i < waits; i++) begin
         start = 1'b1; mode = 3'd0; abs_fld = 32'h55;
         @(negedge clk);
         start = 1'b0;
         chk("R11 req held", 32'(rd_req), 1);
         chk("R11 addr held", 32'(rd_addr), {24'h0, a[7:0]});
      end
      rd_ack = 1'b1; rd_data = data;
      q_addr.push_back(data[23:0]);
      q_odd.push_back(data[0]);
      q_tag.push_back("R8 indirect");
      @(negedge clk);
      rd_ack = 1'b0;
      chk("R8 busy low", 32'(busy), 0);
      chk("R8 req low", 32'(rd_req), 0);
   endtask

   // Monitor: compares every strobe against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && ea_valid) begin
         if (q_addr.size() == 0) begin
            checks++; fails++;
            $display("FAIL R12: unexpected strobe addr %h expected none", ea_addr);
         end else begin
            string t;
            t = q_tag.pop_front();
            chk(t, 32'(ea_addr), 32'(q_addr.pop_front()));
            chk({"R6 odd ", t}, 32'(odd_target), 32'(q_odd.pop_front()));
         end
      end else if (rst_n && odd_target) begin
         checks++; fails++;
         $display("FAIL R6: odd_target 1 without strobe, expected 0");
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ea_valid", 32'(ea_valid), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 rd_req", 32'(rd_req), 0);
      chk("R1 ea_addr", 32'(ea_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int b = 0; b < 8; b++) begin
         imm_code = 3'(b);
         #1 chk("R10 bit_mask", 32'(bit_mask), 32'(1) << b);
      end
      @(negedge clk);
      issue("R2 short", 3'd0, 32'h0000_0012, 0, 0, 0);
      issue("R2 short upper ignored", 3'd0, 32'hABCD_EF80, 0, 0, 0);
      issue("R2 short ff", 3'd0, 32'h0000_00FF, 0, 0, 0);
      issue("R3 mid pos", 3'd1, 32'h1234_7FFF, 0, 0, 0);
      issue("R3 mid neg", 3'd1, 32'h0000_8000, 0, 0, 0);
      issue("R4 prog odd", 3'd2, 32'hFF12_3457, 0, 0, 0);
      issue("R4 long data odd ignored", 3'd3, 32'hAB65_4321, 0, 0, 0);
      issue("R5 near back", 3'd4, 0, 16'h0080, 24'h001000, 0);
      issue("R5 near fwd odd", 3'd4, 0, 16'hFF7F, 24'h001000, 0);
      issue("R5 far wrap up", 3'd5, 0, 16'h0020, 24'hFFFFF0, 0);
      issue("R5 far wrap down", 3'd5, 0, 16'hFFE0, 24'h000010, 0);
      for (int t = 0; t < 4; t++) issue("R9 trap", 3'd7, 0, 0, 0, 3'(t));
      issue("R9 trap high bit ignored", 3'd7, 0, 0, 0, 3'b110);
      @(negedge clk);
      indirect(32'hFFFF_FF44, 32'hDE12_3457, 3);
      indirect(32'h0000_0001, 32'h00AB_CDE0, 0);
      @(negedge clk);
      issue("R12 after indirect", 3'd0, 32'h0000_0001, 0, 0, 0);
      repeat (4) @(negedge clk);
      chk("R12 scoreboard drained", 32'(q_addr.size()), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule